// File: doc/BRIEF.md
# Bit-Plane and Pixel Masked Write Merge Engine

This block sits on the write side of a 32-bit-wide graphics frame memory. It decides, for every write, which stored bits actually change. A stored plane mask can guard bit positions, and each bank can switch that guard on or off when a row is opened. Byte-lane inhibits can block whole bytes on ordinary writes. Block writes fill eight aligned columns at once with a stored colour word, and the data lines carry a per-pixel enable pattern for those columns.

Commands arrive on a single command port with an opcode. The opcodes are 0 idle, 1 open row, 2 write, 3 block write, 4 read, 5 load mask and 6 load colour. Ordinary writes run as bursts of 1, 2, 4 or 8 beats, and a single-write mode forces every write to one beat. A small behavioural array holds the stored words, and a read port makes the merged result visible.

Top module: `pixel_write_merge`

## Requirements
- R1: After reset the plane mask is all ones, the colour word is all zeros, plane masking is off in every bank, and every stored word reads as zero.
- R2: Load mask (op 5) copies `wdata` into the plane mask, and load colour (op 6) copies `wdata` into the colour word.
- R3: Open row (op 1) records `cmd_row` for bank `cmd_bank`. It switches plane masking on for that bank when `cmd_dsf` is 1 and off when it is 0, and leaves the other bank as it was.
- R4: In a bank with plane masking on, a write changes only the bit positions where the plane mask holds 1. All other bits keep their stored value.
- R5: On an ordinary write, `wdqm[b]`=1 keeps byte b (bits 8b+7..8b) of the addressed word unchanged.
- R6: A block write (op 3) ignores the low three bits of `cmd_col` and covers columns base..base+7. Byte b of column base+j takes the colour byte when `wdata[8b+j]` is 1 and is left unchanged when it is 0.
- R7: In a bank with plane masking on, a block write changes a bit only where both its plane mask bit and its pixel enable are 1.
- R8: `wdqm` has no effect on block writes.
- R9: A write whose burst length L = 2^`cfg_bl` is greater than 1 takes data on the command cycle and on the L-1 following cycles. Beat i goes to the column whose low log2(L) bits are (`cmd_col`+i) mod L and whose upper bits come from `cmd_col`. `busy` is high during those following cycles.
- R10: With `cfg_single_write`=1, every write is a single beat whatever `cfg_bl` holds. `busy` stays low, and data on the next cycle is not stored.
- R11: While `busy` is high, `cmd_valid` and the opcode are ignored, and the cycle is taken only as a data beat.
- R12: A read (op 4) sets `rd_valid` one cycle later, with `rd_data` holding the word at `cmd_col` of the row last opened in `cmd_bank`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Opcode: 0 idle, 1 open row, 2 write, 3 block write, 4 read, 5 load mask, 6 load colour |
| cmd_bank | input | 1 | Bank select |
| cmd_row | input | 2 | Row for open row |
| cmd_col | input | 5 | Column address |
| cmd_dsf | input | 1 | Plane masking enable captured by open row |
| wdata | input | 32 | Write data, pixel enables for block write, or register load value |
| wdqm | input | 4 | Per-byte write inhibit for ordinary writes |
| cfg_bl | input | 2 | Burst length code, length 2^cfg_bl |
| cfg_single_write | input | 1 | Forces writes to one beat |
| busy | output | 1 | Burst continuation beats in progress |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |

## Verification
Ordinary writes are run with plane masking off and on, with a partial byte inhibit, and with the two combined, so that a mask applied to the wrong bank or a swapped byte lane shows up. Block writes use a prefilled row, an irregular pixel pattern per lane and an all-ones inhibit. Comparing every column against prior contents separates a wrong column-to-line mapping, a forgotten plane mask and a stray byte inhibit. An eight-beat burst that starts mid-group checks the wrap order. A single-write run followed by stray data checks that nothing extra is stored, and a register load attempted mid-burst checks that commands are ignored while busy.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int DATA_W   = 32;
    localparam int LANE_W   = 8;
    localparam int LANES    = DATA_W / LANE_W;
    localparam int BLK_COLS = 8;
    localparam int BLK_SH   = $clog2(BLK_COLS);

    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_ACT     = 3'd1,
        OP_WRITE   = 3'd2,
        OP_BLOCK   = 3'd3,
        OP_READ    = 3'd4,
        OP_LDMASK  = 3'd5,
        OP_LDCOLOR = 3'd6
    } op_e;

    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        logic  valid;
        word_t data;
        word_t en;
    } beat_t;

    // per-bit enable from byte inhibits (inhibit 1 -> bits off)
    function automatic word_t lane_keep(logic [LANES-1:0] dqm);
        word_t r;
        for (int b = 0; b < LANES; b++)
            r[b*LANE_W +: LANE_W] = {LANE_W{~dqm[b]}};
        return r;
    endfunction

    // per-bit enable of one block column from the pixel lines
    function automatic word_t pixel_keep(word_t dq, logic [BLK_SH-1:0] col);
        word_t r;
        for (int b = 0; b < LANES; b++)
            r[b*LANE_W +: LANE_W] = {LANE_W{dq[b*LANE_W + int'(col)]}};
        return r;
    endfunction

    function automatic word_t merge_bits(word_t old_w, word_t new_w, word_t en);
        return (old_w & ~en) | (new_w & en);
    endfunction

endpackage

// File: rtl/pwm_ctrl_regs.sv
module pwm_ctrl_regs
    import pwm_pkg::*;
#(
    parameter int BANKS  = 2,
    parameter int ROW_W  = 2,
    parameter int BANK_W = 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        accept,
    input  op_e                         op,
    input  logic [BANK_W-1:0]           bank,
    input  logic [ROW_W-1:0]            row,
    input  logic                        dsf,
    input  word_t                       wdata,
    output word_t                       mask_q,
    output word_t                       colour_q,
    output logic [BANKS-1:0]            wpb_q,
    output logic [BANKS-1:0][ROW_W-1:0] open_row_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q     <= '1;
            colour_q   <= '0;
            wpb_q      <= '0;
            open_row_q <= '0;
        end else if (accept) begin
            unique case (op)
                OP_LDMASK:  mask_q   <= wdata;
                OP_LDCOLOR: colour_q <= wdata;
                OP_ACT: begin
                    wpb_q[bank]      <= dsf;
                    open_row_q[bank] <= row;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pwm_burst_seq.sv
module pwm_burst_seq #(
    parameter int COL_W  = 5,
    parameter int BANK_W = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic [1:0]        cfg_bl,
    input  logic              cfg_single,
    output logic              busy,
    output logic [BANK_W-1:0] beat_bank,
    output logic [COL_W-1:0]  beat_col
);

    localparam int CNT_W = 3;

    logic [3:0]        blen;
    logic [COL_W-1:0]  len_m;
    logic              busy_q;
    logic [CNT_W-1:0]  remain_q;
    logic [BANK_W-1:0] bank_q;
    logic [COL_W-1:0]  base_q, off_q, lenm_q;

    assign blen  = cfg_single ? 4'd1 : (4'd1 << cfg_bl);
    assign len_m = COL_W'(blen - 4'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            remain_q <= '0;
            bank_q   <= '0;
            base_q   <= '0;
            off_q    <= '0;
            lenm_q   <= '0;
        end else if (busy_q) begin
            remain_q <= remain_q - 1'b1;
            off_q    <= (off_q + 1'b1) & lenm_q;
            if (remain_q == CNT_W'(1))
                busy_q <= 1'b0;
        end else if (start && len_m != '0) begin
            busy_q   <= 1'b1;
            remain_q <= len_m[CNT_W-1:0];
            bank_q   <= cmd_bank;
            base_q   <= cmd_col & ~len_m;
            off_q    <= (cmd_col + 1'b1) & len_m;
            lenm_q   <= len_m;
        end
    end

    assign busy      = busy_q;
    assign beat_bank = bank_q;
    assign beat_col  = base_q | off_q;

endmodule

// File: rtl/pwm_merge_mem.sv
module pwm_merge_mem
    import pwm_pkg::*;
#(
    parameter int BANK_W = 1,
    parameter int ROW_W  = 2,
    parameter int COL_W  = 5
) (
    input  logic                              clk,
    input  logic                              rst,
    input  beat_t                             nb,
    input  logic [BANK_W-1:0]                 nb_bank,
    input  logic [ROW_W-1:0]                  nb_row,
    input  logic [COL_W-1:0]                  nb_col,
    input  logic                              blk_valid,
    input  logic [BANK_W-1:0]                 blk_bank,
    input  logic [ROW_W-1:0]                  blk_row,
    input  logic [COL_W-BLK_SH-1:0]           blk_hi,
    input  word_t                             colour,
    input  logic [BLK_COLS-1:0][DATA_W-1:0]   blk_en,
    input  logic                              rd_req,
    input  logic [BANK_W-1:0]                 rd_bank,
    input  logic [ROW_W-1:0]                  rd_row,
    input  logic [COL_W-1:0]                  rd_col,
    output logic                              rd_valid,
    output word_t                             rd_data
);

    localparam int ADDR_W = BANK_W + ROW_W + COL_W;
    localparam int DEPTH  = 1 << ADDR_W;

    word_t             mem [DEPTH];
    logic [ADDR_W-1:0] nidx, ridx;

    assign nidx = {nb_bank, nb_row, nb_col};
    assign ridx = {rd_bank, rd_row, rd_col};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            if (nb.valid)
                mem[nidx] <= merge_bits(mem[nidx], nb.data, nb.en);
            if (blk_valid) begin
                for (int j = 0; j < BLK_COLS; j++)
                    mem[{blk_bank, blk_row, blk_hi, BLK_SH'(j)}] <=
                        merge_bits(mem[{blk_bank, blk_row, blk_hi, BLK_SH'(j)}],
                                   colour, blk_en[j]);
            end
            rd_valid <= rd_req;
            if (rd_req)
                rd_data <= mem[ridx];
        end
    end

endmodule

// File: rtl/pixel_write_merge.sv
module pixel_write_merge
    import pwm_pkg::*;
#(
    parameter int BANKS = 2,
    parameter int ROW_W = 2,
    parameter int COL_W = 5,
    localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [ROW_W-1:0]  cmd_row,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic              cmd_dsf,
    input  logic [31:0]       wdata,
    input  logic [3:0]        wdqm,
    input  logic [1:0]        cfg_bl,
    input  logic              cfg_single_write,
    output logic              busy,
    output logic              rd_valid,
    output logic [31:0]       rd_data
);

    op_e                         op;
    logic                        accept, wr_start, blk_start, rd_start;
    word_t                       mask_q, colour_q;
    logic [BANKS-1:0]            wpb_q;
    logic [BANKS-1:0][ROW_W-1:0] open_row_q;
    logic [BANK_W-1:0]           beat_bank, w_bank;
    logic [COL_W-1:0]            beat_col, w_col;
    word_t                       w_plane, b_plane;
    beat_t                       nb;
    logic [BLK_COLS-1:0][DATA_W-1:0] blk_en;

    assign op        = op_e'(cmd_op);
    assign accept    = cmd_valid && !busy;
    assign wr_start  = accept && (op == OP_WRITE);
    assign blk_start = accept && (op == OP_BLOCK);
    assign rd_start  = accept && (op == OP_READ);

    pwm_ctrl_regs #(.BANKS(BANKS), .ROW_W(ROW_W), .BANK_W(BANK_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .op         (op),
        .bank       (cmd_bank),
        .row        (cmd_row),
        .dsf        (cmd_dsf),
        .wdata      (wdata),
        .mask_q     (mask_q),
        .colour_q   (colour_q),
        .wpb_q      (wpb_q),
        .open_row_q (open_row_q)
    );

    pwm_burst_seq #(.COL_W(COL_W), .BANK_W(BANK_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (wr_start),
        .cmd_bank   (cmd_bank),
        .cmd_col    (cmd_col),
        .cfg_bl     (cfg_bl),
        .cfg_single (cfg_single_write),
        .busy       (busy),
        .beat_bank  (beat_bank),
        .beat_col   (beat_col)
    );

    // ordinary write beat: command cycle or burst continuation
    assign w_bank   = busy ? beat_bank : cmd_bank;
    assign w_col    = busy ? beat_col  : cmd_col;
    assign w_plane  = wpb_q[w_bank] ? mask_q : '1;
    assign nb.valid = busy || wr_start;
    assign nb.data  = wdata;
    assign nb.en    = w_plane & lane_keep(wdqm);

    // block write: one enable word per covered column
    assign b_plane = wpb_q[cmd_bank] ? mask_q : '1;

    for (genvar j = 0; j < BLK_COLS; j++) begin : g_blk_col
        assign blk_en[j] = b_plane & pixel_keep(wdata, BLK_SH'(j));
    end

    pwm_merge_mem #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_mem (
        .clk       (clk),
        .rst       (rst),
        .nb        (nb),
        .nb_bank   (w_bank),
        .nb_row    (open_row_q[w_bank]),
        .nb_col    (w_col),
        .blk_valid (blk_start),
        .blk_bank  (cmd_bank),
        .blk_row   (open_row_q[cmd_bank]),
        .blk_hi    (cmd_col[COL_W-1:BLK_SH]),
        .colour    (colour_q),
        .blk_en    (blk_en),
        .rd_req    (rd_start),
        .rd_bank   (cmd_bank),
        .rd_row    (open_row_q[cmd_bank]),
        .rd_col    (cmd_col),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/pwm_checker.sv
module pwm_checker #(
    parameter int BANKS  = 2,
    parameter int BANK_W = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic [BANK_W-1:0] cmd_bank,
    input logic              cmd_dsf,
    input logic [1:0]        cfg_bl,
    input logic              cfg_single_write,
    input logic              busy,
    input logic              rd_valid,
    input logic [31:0]       mask_q,
    input logic [31:0]       colour_q,
    input logic [BANKS-1:0]  wpb_q
);

    assert_wpb_follows_dsf_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy && cmd_op == 3'd1) |=> (wpb_q[$past(cmd_bank)] == $past(cmd_dsf)));

    assert_burst_busy_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy && cmd_op == 3'd2 && cfg_bl != 2'd0 && !cfg_single_write) |=> busy);

    assert_single_no_busy_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy && cmd_op == 3'd2 && cfg_single_write) |=> !busy);

    assert_regs_hold_busy_R11: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(mask_q) && $stable(colour_q) && $stable(wpb_q)));

    assert_read_latency_R12: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy && cmd_op == 3'd4) |=> rd_valid);

    assert_read_origin_R12: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(cmd_valid && !busy && cmd_op == 3'd4));

endmodule

bind pixel_write_merge pwm_checker #(.BANKS(BANKS), .BANK_W(BANK_W)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .cmd_valid        (cmd_valid),
    .cmd_op           (cmd_op),
    .cmd_bank         (cmd_bank),
    .cmd_dsf          (cmd_dsf),
    .cfg_bl           (cfg_bl),
    .cfg_single_write (cfg_single_write),
    .busy             (busy),
    .rd_valid         (rd_valid),
    .mask_q           (mask_q),
    .colour_q         (colour_q),
    .wpb_q            (wpb_q)
);

// File: tb/tb_pixel_write_merge.sv
module tb_pixel_write_merge;
    import pwm_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [0:0]  cmd_bank = 1'b0;
    logic [1:0]  cmd_row = 2'd0;
    logic [4:0]  cmd_col = 5'd0;
    logic        cmd_dsf = 1'b0;
    logic [31:0] wdata = 32'd0;
    logic [3:0]  wdqm = 4'd0;
    logic [1:0]  cfg_bl = 2'd0;
    logic        cfg_single_write = 1'b0;
    logic        busy, rd_valid;
    logic [31:0] rd_data;

    pixel_write_merge dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
        .cmd_dsf(cmd_dsf), .wdata(wdata), .wdqm(wdqm), .cfg_bl(cfg_bl),
        .cfg_single_write(cfg_single_write), .busy(busy),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    always #5 clk = ~clk;

    // reference model
    logic [31:0] mem_m [2][4][32];
    logic [31:0] mask_m = 32'hFFFF_FFFF;
    logic [31:0] colour_m = 32'h0;
    bit          wpb_m [2];
    int          row_m [2];

    logic [31:0] exp_q [$];
    string       tag_q [$];
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R12: unexpected read data %h expected none", rd_data);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(t, rd_data, e);
            end
        end
    end

    function automatic logic [31:0] plane(input int bank);
        return wpb_m[bank] ? mask_m : 32'hFFFF_FFFF;
    endfunction

    task automatic clear_cmd();
        cmd_valid = 1'b0; cmd_op = 3'd0; wdqm = 4'd0;
    endtask

    task automatic do_act(input int bank, input int row, input bit dsf);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = OP_ACT; cmd_bank = 1'(bank);
        cmd_row = 2'(row); cmd_dsf = dsf;
        wpb_m[bank] = dsf; row_m[bank] = row;
        @(negedge clk); clear_cmd();
    endtask

    task automatic do_load(input op_e op, input logic [31:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; wdata = d;
        if (op == OP_LDMASK) mask_m = d; else colour_m = d;
        @(negedge clk); clear_cmd();
    endtask

    task automatic do_write(input int bank, input int col, input logic [3:0] dqm,
                            input logic [7:0][31:0] d, input bit intr, input string req);
        int len, base, c;
        logic [31:0] en;
        len  = cfg_single_write ? 1 : (1 << cfg_bl);
        base = col & ~(len - 1);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (i > 0) chk(req, {31'd0, busy}, 32'd1);
            if (i == 0) begin
                cmd_valid = 1'b1; cmd_op = OP_WRITE;
                cmd_bank = 1'(bank); cmd_col = 5'(col);
            end else begin
                cmd_valid = intr && (i == 1);
                cmd_op    = (intr && i == 1) ? OP_LDMASK : OP_NOP;
            end
            wdata = d[i]; wdqm = dqm;
            c  = base | ((col + i) & (len - 1));
            en = plane(bank);
            for (int b = 0; b < 4; b++) if (dqm[b]) en[b*8 +: 8] = 8'h00;
            mem_m[bank][row_m[bank]][c] = (mem_m[bank][row_m[bank]][c] & ~en) | (d[i] & en);
        end
        @(negedge clk);
        chk(req, {31'd0, busy}, 32'd0);
        clear_cmd();
        wdata = ~d[0];
        @(negedge clk);
    endtask

    task automatic do_block(input int bank, input int col, input logic [31:0] dq,
                            input logic [3:0] dqm);
        int base;
        logic [31:0] en;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = OP_BLOCK; cmd_bank = 1'(bank);
        cmd_col = 5'(col); wdata = dq; wdqm = dqm;
        base = col & ~7;
        for (int j = 0; j < 8; j++) begin
            en = plane(bank);
            for (int b = 0; b < 4; b++) if (!dq[b*8 + j]) en[b*8 +: 8] = 8'h00;
            mem_m[bank][row_m[bank]][base + j] =
                (mem_m[bank][row_m[bank]][base + j] & ~en) | (colour_m & en);
        end
        @(negedge clk); clear_cmd();
    endtask

    task automatic do_read(input int bank, input int col, input string req);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = OP_READ; cmd_bank = 1'(bank); cmd_col = 5'(col);
        exp_q.push_back(mem_m[bank][row_m[bank]][col]);
        tag_q.push_back(req);
        @(negedge clk); clear_cmd();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int b = 0; b < 2; b++) begin
            wpb_m[b] = 1'b0; row_m[b] = 0;
            for (int r = 0; r < 4; r++)
                for (int c = 0; c < 32; c++) mem_m[b][r][c] = 32'h0;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", {31'd0, busy}, 32'd0);

        // R1: stored words start at zero
        do_act(0, 1, 1'b0);
        do_read(0, 0, "R1");
        do_read(0, 5, "R1");

        // R5: byte inhibits on plain writes
        do_write(0, 3, 4'b0000, {7'd0, 32'h1122_3344}, 1'b0, "R5");
        do_read(0, 3, "R5");
        do_write(0, 3, 4'b0101, {7'd0, 32'hAABB_CCDD}, 1'b0, "R5");
        do_read(0, 3, "R5");

        // R1: reset mask is all ones, so plane masking passes everything
        do_act(1, 2, 1'b1);
        do_write(1, 7, 4'b0000, {7'd0, 32'hDEAD_BEEF}, 1'b0, "R1");
        do_read(1, 7, "R1");

        // R2 / R4: loaded mask guards bit planes
        do_load(OP_LDMASK, 32'h0F0F_00FF);
        do_write(1, 7, 4'b0000, {7'd0, 32'h1234_5678}, 1'b0, "R4");
        do_read(1, 7, "R4");
        do_write(1, 9, 4'b0001, {7'd0, 32'hFFFF_FFFF}, 1'b0, "R4");
        do_read(1, 9, "R4");

        // R3: per-bank enable
        do_write(0, 4, 4'b0000, {7'd0, 32'hCAFE_F00D}, 1'b0, "R3");
        do_read(0, 4, "R3");
        do_act(1, 2, 1'b0);
        do_write(1, 7, 4'b0000, {7'd0, 32'h5555_AAAA}, 1'b0, "R3");
        do_read(1, 7, "R3");

        // R9: 8-beat burst from mid-group wraps
        cfg_bl = 2'd3;
        do_write(0, 11, 4'b0000, {32'h8888_0007, 32'h7777_0006, 32'h6666_0005,
                 32'h5555_0004, 32'h4444_0003, 32'h3333_0002, 32'h2222_0001,
                 32'h1111_0000}, 1'b0, "R9");
        for (int c = 8; c < 16; c++) do_read(0, c, "R9");

        // R1: reset colour is zero
        do_block(0, 13, 32'hFFFF_FFFF, 4'b0000);
        for (int c = 8; c < 16; c++) do_read(0, c, "R1");

        // R6 / R8: pixel pattern, inhibits set but ignored
        do_write(0, 8, 4'b0000, {32'h0F0F_0F0F, 32'hF0F0_F0F0, 32'h3333_3333,
                 32'hCCCC_CCCC, 32'h0101_0101, 32'h8080_8080, 32'h7E7E_7E7E,
                 32'h1357_9BDF}, 1'b0, "R9");
        do_load(OP_LDCOLOR, 32'hA5C3_3C5A);
        do_block(0, 14, 32'h813C_F00F, 4'b1111);
        for (int c = 8; c < 16; c++) do_read(0, c, "R6 R8");

        // R7: plane mask combined with pixel mask
        do_write(1, 0, 4'b0000, {32'h7070_7070, 32'h6060_6060, 32'h5050_5050,
                 32'h4040_4040, 32'h3030_3030, 32'h2020_2020, 32'h1010_1010,
                 32'h0000_0000}, 1'b0, "R9");
        do_act(1, 2, 1'b1);
        do_block(1, 3, 32'h55AA_0FF0, 4'b0000);
        for (int c = 0; c < 8; c++) do_read(1, c, "R7");

        // R10: single write overrides burst length
        cfg_single_write = 1'b1;
        do_write(0, 20, 4'b0000, {7'd0, 32'h0BAD_CAFE}, 1'b0, "R10");
        do_read(0, 20, "R10");
        do_read(0, 21, "R10");
        cfg_single_write = 1'b0;

        // R11: load attempted mid-burst is ignored
        cfg_bl = 2'd2;
        do_write(0, 17, 4'b0000, {32'd0, 32'd0, 32'd0, 32'd0,
                 32'h4444_4444, 32'h3333_3333, 32'hFFFF_0000, 32'h1111_1111},
                 1'b1, "R11");
        for (int c = 16; c < 20; c++) do_read(0, c, "R11");
        cfg_bl = 2'd0;
        do_act(1, 3, 1'b1);
        do_write(1, 0, 4'b0000, {7'd0, 32'hFFFF_FFFF}, 1'b0, "R11");
        do_read(1, 0, "R11");

        repeat (4) @(negedge clk);
        chk("R12", 32'(exp_q.size()), 32'd0);
        finish_run();
    end

endmodule